// File: doc/BRIEF.md
# Double-Data-Rate Nibble Frame Transmitter

This block takes byte-wide frames from a streaming source and turns them into the 4-bit, two-phase transmit format used by reduced-pin gigabit Ethernet PHYs. Every clock cycle carries two phases, a rising-edge phase and a falling-edge phase. Each phase carries a 4-bit data value and a control bit. The output pins of the block hold one registered pair per cycle. The pad-level DDR cells outside the block put the rising-phase value on the wire after the rising edge and the falling-phase value after the falling edge.

The block has two rates, chosen by `gig_mode`. At gigabit rate a byte leaves in one cycle: the low nibble goes in the rising phase and the high nibble in the falling phase. At 10/100 rate each nibble takes a whole cycle and appears in both phases, low nibble first. In that case the source is throttled with `s_ready`. The rising-phase control bit marks every cycle that carries frame data. The falling-phase control bit equals data-valid XOR error. A frame whose last byte is flagged as bad is therefore marked by a low falling-phase control on that last byte.

The input follows valid/ready rules. A byte transfers on a clock edge where `s_valid` and `s_ready` are both high. While `s_valid` is high and the byte has not transferred, the source must hold the byte and its flags steady. At gigabit rate `s_ready` is always high. At 10/100 rate it drops for one cycle after each transfer while the high nibble goes out. Within a frame the source must present bytes back to back, so that the transmit control stays high without gaps. `gig_mode` may change only between frames.

Top module: `ddr_nibble_tx`

## Requirements
- R1: After reset, and in every cycle that carries no frame nibble, both data phases are 0 and both control phases are low.
- R2: With `gig_mode`=1, `s_ready` is always 1. A byte accepted at a clock edge appears right after that edge: bits [3:0] in `txd_rise`, bits [7:4] in `txd_fall`, with `txc_rise`=1.
- R3: With `gig_mode`=0, a byte accepted at a clock edge gives, right after that edge, bits [3:0] on both `txd_rise` and `txd_fall`. After the next edge it gives bits [7:4] on both. `txc_rise`=1 in both cycles.
- R4: With `gig_mode`=0, `s_ready` is 0 in the cycle that follows a frame-byte transfer and 1 otherwise. No accepted byte is lost.
- R5: A frame presented back to back keeps `txc_rise` high from its first nibble to its last high nibble with no gap.
- R6: `txc_fall` equals `txc_rise` XOR bad. Bad is 1 only for the nibbles of a byte accepted with both `s_eop`=1 and `s_err`=1.
- R7: `s_err` on a byte without `s_eop` has no effect: that byte is sent with `txc_fall`=1.
- R8: A byte accepted outside a frame is consumed and dropped. A frame starts with an `s_sop`=1 byte and ends with an `s_eop`=1 byte. A dropped byte produces idle output and does not stall `s_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gig_mode | input | 1 | 1 = one byte per cycle, 0 = one nibble per cycle |
| s_valid | input | 1 | Source byte valid |
| s_ready | output | 1 | Block can take a byte |
| s_data | input | 8 | Source byte |
| s_sop | input | 1 | First byte of a frame |
| s_eop | input | 1 | Last byte of a frame |
| s_err | input | 1 | Frame is bad (honoured only with s_eop) |
| txd_rise | output | 4 | Data for the rising-edge phase |
| txd_fall | output | 4 | Data for the falling-edge phase |
| txc_rise | output | 1 | Control for the rising-edge phase (data valid) |
| txc_fall | output | 1 | Control for the falling-edge phase (valid XOR error) |

## Verification
At 10/100 rate, two events can fall in the same cycle: the high nibble of the last byte is still going out, and the next frame's first byte, or a stray byte, is already waiting. The bench provokes this by starting frames with zero gap and by inserting stray bytes between frames. It checks that `s_ready` stays low for exactly that cycle and that the pending high nibble still carries the bad marking of the ending frame. A second overlap is an error flag raised on a mid-frame byte in the same cycle that another frame's end-of-packet arrives with error. Seeded random stimulus mixes the two rates, random gaps and random error flags, and every phase is compared with a model built from the requirements.

// File: rtl/dnt_pkg.sv
package dnt_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // One cycle worth of line content before the output registers.
  typedef struct packed {
    logic vld;
    logic bad;
    nib_t rise;
    nib_t fall;
  } phase_pair_t;
endpackage

// File: rtl/dnt_pacer.sv
module dnt_pacer
  import dnt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gig_mode,
  input  logic        s_valid,
  output logic        s_ready,
  input  byte_t       s_data,
  input  logic        s_sop,
  input  logic        s_eop,
  input  logic        s_err,
  output phase_pair_t pair
);
  logic  hold_q;
  nib_t  hi_q;
  logic  hbad_q;
  logic  inf_q;
  logic  fire;
  logic  take;
  logic  bad_now;
  nib_t  lo_n;
  nib_t  hi_n;

  assign lo_n    = s_data[NIB_W-1:0];
  assign hi_n    = s_data[BYTE_W-1:NIB_W];
  assign s_ready = gig_mode | ~hold_q;
  assign fire    = s_valid & s_ready;
  assign take    = fire & (s_sop | inf_q);
  assign bad_now = s_err & s_eop;

  always_comb begin
    pair = '0;
    if (gig_mode) begin
      if (take) begin
        pair.vld  = 1'b1;
        pair.bad  = bad_now;
        pair.rise = lo_n;
        pair.fall = hi_n;
      end
    end else if (hold_q) begin
      pair.vld  = 1'b1;
      pair.bad  = hbad_q;
      pair.rise = hi_q;
      pair.fall = hi_q;
    end else if (take) begin
      pair.vld  = 1'b1;
      pair.bad  = bad_now;
      pair.rise = lo_n;
      pair.fall = lo_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      hi_q   <= '0;
      hbad_q <= 1'b0;
      inf_q  <= 1'b0;
    end else begin
      if (fire) begin
        if (s_eop)      inf_q <= 1'b0;
        else if (s_sop) inf_q <= 1'b1;
      end
      if (gig_mode || hold_q) begin
        hold_q <= 1'b0;
      end else if (take) begin
        hold_q <= 1'b1;
        hi_q   <= hi_n;
        hbad_q <= bad_now;
      end
    end
  end
endmodule

// File: rtl/dnt_phase_out.sv
module dnt_phase_out
  import dnt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  phase_pair_t pair,
  output nib_t        txd_rise,
  output nib_t        txd_fall,
  output logic        txc_rise,
  output logic        txc_fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_rise <= '0;
      txd_fall <= '0;
      txc_rise <= 1'b0;
      txc_fall <= 1'b0;
    end else begin
      txd_rise <= pair.vld ? pair.rise : '0;
      txd_fall <= pair.vld ? pair.fall : '0;
      txc_rise <= pair.vld;
      txc_fall <= pair.vld ^ (pair.vld & pair.bad);
    end
  end
endmodule

// File: rtl/ddr_nibble_tx.sv
module ddr_nibble_tx
  import dnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gig_mode,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_sop,
  input  logic              s_eop,
  input  logic              s_err,
  output logic [NIB_W-1:0]  txd_rise,
  output logic [NIB_W-1:0]  txd_fall,
  output logic              txc_rise,
  output logic              txc_fall
);
  phase_pair_t pair;

  dnt_pacer u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .gig_mode (gig_mode),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_data   (s_data),
    .s_sop    (s_sop),
    .s_eop    (s_eop),
    .s_err    (s_err),
    .pair     (pair)
  );

  dnt_phase_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pair     (pair),
    .txd_rise (txd_rise),
    .txd_fall (txd_fall),
    .txc_rise (txc_rise),
    .txc_fall (txc_fall)
  );
endmodule

// File: rtl/ddr_nibble_tx_chk.sv
module ddr_nibble_tx_chk
  import dnt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              gig_mode,
  input logic              s_valid,
  input logic              s_ready,
  input logic [BYTE_W-1:0] s_data,
  input logic              s_sop,
  input logic              s_eop,
  input logic              s_err,
  input logic [NIB_W-1:0]  txd_rise,
  input logic [NIB_W-1:0]  txd_fall,
  input logic              txc_rise,
  input logic              txc_fall
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !txc_rise |-> (txd_rise == '0 && txd_fall == '0 && !txc_fall)); // R1

  AST_GIG_READY: assert property (@(posedge clk) disable iff (!rst_n)
    gig_mode |-> s_ready); // R2

  AST_GIG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (gig_mode && s_valid && s_ready && s_sop) |=>
      (txc_rise && txd_rise == $past(s_data[NIB_W-1:0]) &&
       txd_fall == $past(s_data[BYTE_W-1:NIB_W]))); // R2

  AST_SLOW_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gig_mode && s_valid && s_ready && s_sop) |=>
      (txc_rise && txd_rise == txd_fall)); // R3

  AST_SLOW_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gig_mode && s_valid && s_ready && s_sop) |=> (gig_mode || !s_ready)); // R4

  AST_BAD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_sop && s_eop && s_err) |=> (txc_rise && !txc_fall)); // R6

  AST_ERR_NO_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_sop && !s_eop && s_err) |=> (txc_rise && txc_fall)); // R7
endmodule

bind ddr_nibble_tx ddr_nibble_tx_chk i_chk (.*);

// File: tb/test_ddr_nibble_tx.sv
module test_ddr_nibble_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gig_mode = 1'b1;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       s_sop = 1'b0;
  logic       s_eop = 1'b0;
  logic       s_err = 1'b0;
  logic [3:0] txd_rise, txd_fall;
  logic       txc_rise, txc_fall;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddr_nibble_tx i_ddr_nibble_tx (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected line word packed as {cr, cf, rise, fall}
  function automatic logic [9:0] line_word(bit v, bit bad, logic [3:0] r, logic [3:0] f);
    return v ? {1'b1, ~bad, r, f} : 10'd0;
  endfunction

  initial begin
    #(10 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] exp_w;
    logic [9:0] act_w;
    bit   m_hold, m_inf, m_hbad;
    logic [3:0] m_hi;
    bit   cur_v;
    int   left, gap;
    bit   rdy_e, fire, take, bad;
    void'($urandom(32'd4242));
    m_hold = 0; m_inf = 0; m_hbad = 0; m_hi = '0;
    cur_v = 0; left = 0; gap = 0;
    exp_w = '0;

    repeat (3) @(negedge clk);
    chk({txc_rise, txc_fall, txd_rise, txd_fall} == 10'd0, "R1 reset", 
        {txc_rise, txc_fall, txd_rise, txd_fall}, 0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      act_w = {txc_rise, txc_fall, txd_rise, txd_fall};
      if (exp_w[9])
        chk(act_w == exp_w, gig_mode ? "R2/R5/R6/R7 frame phases" : "R3/R5/R6/R7 frame phases",
            act_w, exp_w);
      else
        chk(act_w == exp_w, "R1/R8 idle phases", act_w, exp_w);

      // choose stimulus
      if (!cur_v) begin
        s_sop = 0; s_eop = 0; s_err = 0; s_valid = 0;
        if (left > 0) begin
          cur_v = 1; s_valid = 1; s_data = 8'($urandom);
          s_eop = (left == 1);
          s_err = ($urandom_range(0, 3) == 0);
          left--;
        end else if (gap > 0) begin
          gap--;
          if ($urandom_range(0, 3) == 0) begin  // R8 stray byte outside a frame
            cur_v = 1; s_valid = 1; s_data = 8'($urandom);
            s_err = $urandom_range(0, 1);
          end
        end else begin
          if (!m_hold && $urandom_range(0, 7) == 0) gig_mode = ~gig_mode;
          left = $urandom_range(1, 6);
          gap  = $urandom_range(0, 3);
          cur_v = 1; s_valid = 1; s_sop = 1; s_data = 8'($urandom);
          s_eop = (left == 1);
          s_err = ($urandom_range(0, 2) == 0);
          left--;
        end
      end
      #1;
      rdy_e = gig_mode | ~m_hold;
      chk(s_ready == rdy_e, gig_mode ? "R2 ready" : "R4 ready", s_ready, rdy_e);
      fire = s_valid & rdy_e;
      take = fire & (s_sop | m_inf);
      bad  = s_err & s_eop;
      if (gig_mode) begin
        exp_w = line_word(take, bad, s_data[3:0], s_data[7:4]);
        m_hold = 0;
      end else if (m_hold) begin
        exp_w = line_word(1, m_hbad, m_hi, m_hi);
        m_hold = 0;
      end else begin
        exp_w = line_word(take, bad, s_data[3:0], s_data[3:0]);
        if (take) begin m_hold = 1; m_hi = s_data[7:4]; m_hbad = bad; end
      end
      if (fire) begin
        if (s_eop) m_inf = 0;
        else if (s_sop) m_inf = 1;
        cur_v = 0;
      end
    end

    // drain and final idle check
    @(negedge clk);
    s_valid = 0; s_sop = 0; s_eop = 0; s_err = 0;
    repeat (3) @(negedge clk);
    chk({txc_rise, txc_fall, txd_rise, txd_fall} == 10'd0, "R1 final idle",
        {txc_rise, txc_fall, txd_rise, txd_fall}, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule